// File: doc/BRIEF.md
# Parallel Gaussian Noise Sample Generator

This block supplies a wide bus of Gaussian-distributed noise samples for a hardware channel emulator. Each lane forms one sample per enabled clock with a quantized Box–Muller transform. Two 64-bit linear feedback shift registers give two uniform 8-bit words. One word addresses a radius table holding sqrt(-2 ln u). The other addresses an angle table holding cos(2πu). The two table values are multiplied. The product is then scaled by an 8-bit factor that software derives from the target signal-to-noise ratio, and saturated to a 6-bit two's-complement sample.

Sixteen lanes run side by side by default. Each lane has its own pair of seeds, derived from one shared 64-bit seed word. The lanes share the two constant tables, which are computed while the design elaborates. A single valid flag marks the cycles in which the whole bus holds fresh samples.

Top module: `gng_array`

## Requirements
- R1: While reset (active-low `rst_n`) is low, and in the cycle after it, `valid` is 0 and every sample is 0.
- R2: Each lane holds two 64-bit shift registers, generator 0 (radius) and generator 1 (angle). On every edge where `en` is 1 and `seed_load` is 0, each register steps 8 times. One step shifts left by one and enters s[63]^s[62]^s[60]^s[59] into bit 0. With `en` at 0, the state holds.
- R3: On an edge with `seed_load` at 1, generator g of lane i loads seed XOR (64'h9E3779B97F4A7C15 * (2i+g+1)) mod 2^64. If that value is zero, it loads all ones instead. A load takes priority over stepping. Reset loads the same values computed with a seed of zero.
- R4: The table indexes are bits [63:56] of each generator's state before the step. The radius entry at k is round(64*sqrt(-2 ln((k+0.5)/256))), unsigned. The angle entry at k is round(127*cos(2π(k+0.5)/256)), signed, with rounding half away from zero.
- R5: A lane's sample is floor(radius * angle * scale / 2^17). Here `scale` is unsigned and is taken on the last pipeline edge.
- R6: A sample saturates to 31 above and to -32 below, with no wrap.
- R7: When `en` is 1 at edge t, `valid` is 1 after edge t+2, and the samples then hold the values computed from the state seen at edge t. When `en` is 0 at edge t, `valid` is 0 after edge t+2.
- R8: Lane i drives `samples[6i+5:6i]`. Lanes carry different seeds and so produce different sequences.
- R9: With `scale` at 0, every sample is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Step the generators and launch one sample set |
| seed_load | input | 1 | Load per-lane seeds derived from `seed` |
| seed | input | 64 | Shared seed word |
| scale | input | 8 | Noise amplitude factor, 4 fractional bits of standard deviation in LSBs |
| samples | output | LANES*6 | Packed signed samples, lane 0 in the low bits |
| valid | output | 1 | Samples hold a fresh set |

## Verification
The bench builds the block with its default sixteen lanes, 8-bit table indexes and a 2^17 scaling shift. With those values every lane's seed derivation and bus position is exercised. A scale of 255 then drives the product far past the 6-bit range on both signs, so both saturation limits are reached within a few dozen samples. A shared seed equal to the first mixing constant puts lane 0's radius generator onto the zero-seed replacement path. Irregular enable patterns test the hold of state and the three-edge valid timing.

// File: rtl/gng_pkg.sv
package gng_pkg;
    localparam int LFSR_W   = 64;
    localparam int IDX_W    = 8;
    localparam int TAB_N    = 2 ** IDX_W;
    localparam int RAD_W    = 8;
    localparam int ANG_W    = 8;
    localparam int SCALE_W  = 8;
    localparam int SAMPLE_W = 6;
    localparam int SHIFT    = 17;
    localparam int RAD_FRAC = 64;
    localparam int ANG_AMP  = 127;
    localparam int PROD_W   = RAD_W + 1 + ANG_W;
    localparam int WIDE_W   = PROD_W + SCALE_W + 1;
    localparam int SMAX     = 2 ** (SAMPLE_W - 1) - 1;
    localparam int SMIN     = -(2 ** (SAMPLE_W - 1));
    localparam logic [LFSR_W-1:0] MIX_K = 64'h9E3779B97F4A7C15;

    typedef logic [RAD_W-1:0]        rad_tab_t [TAB_N];
    typedef logic signed [ANG_W-1:0] ang_tab_t [TAB_N];

    function automatic int round_real(input real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        else          return -$rtoi(-x + 0.5);
    endfunction

    function automatic rad_tab_t build_rad_tab();
        rad_tab_t t;
        for (int k = 0; k < TAB_N; k++) begin
            real u;
            int  v;
            u = ($itor(k) + 0.5) / $itor(TAB_N);
            v = round_real($sqrt(-2.0 * $ln(u)) * $itor(RAD_FRAC));
            if (v > 2 ** RAD_W - 1) v = 2 ** RAD_W - 1;
            t[k] = RAD_W'(v);
        end
        return t;
    endfunction

    function automatic ang_tab_t build_ang_tab();
        ang_tab_t t;
        for (int k = 0; k < TAB_N; k++) begin
            real a;
            a = 6.283185307179586 * ($itor(k) + 0.5) / $itor(TAB_N);
            t[k] = ANG_W'(round_real($cos(a) * $itor(ANG_AMP)));
        end
        return t;
    endfunction

    localparam rad_tab_t RAD_TAB = build_rad_tab();
    localparam ang_tab_t ANG_TAB = build_ang_tab();

    typedef struct packed {
        logic [LFSR_W-1:0] state;
    } lfsr_t;

    typedef struct packed {
        logic [RAD_W-1:0]           rad;
        logic signed [ANG_W-1:0]    ang;
        logic signed [PROD_W-1:0]   prod;
        logic signed [SAMPLE_W-1:0] smp;
    } lane_pipe_t;

    typedef struct packed {
        logic [2:0] vpipe;
    } top_t;
endpackage

// File: rtl/gng_lfsr.sv
module gng_lfsr
    import gng_pkg::*;
#(
    parameter int LANE = 0,
    parameter int GEN  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [LFSR_W-1:0] MIX = LFSR_W'(MIX_K * LFSR_W'(2 * LANE + GEN + 1));

    lfsr_t r_d, r_q;
    logic [LFSR_W-1:0] mixed;
    logic [LFSR_W-1:0] stepped;

    always_comb begin
        mixed = seed ^ MIX;
        if (mixed == '0) mixed = '1;
        stepped = r_q.state;
        for (int s = 0; s < IDX_W; s++) begin
            stepped = {stepped[LFSR_W-2:0],
                       stepped[63] ^ stepped[62] ^ stepped[60] ^ stepped[59]};
        end
        r_d = r_q;
        if (load)         r_d.state = mixed;
        else if (advance) r_d.state = stepped;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q.state <= MIX;
        else        r_q <= r_d;
    end

    assign idx = r_q.state[LFSR_W-1 -: IDX_W];

    p_state_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.state != '0);

    p_step_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load) |=> r_q.state != $past(r_q.state));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load) |=> $stable(r_q.state));
endmodule

// File: rtl/gng_lane.sv
module gng_lane
    import gng_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic                       seed_load,
    input  logic [LFSR_W-1:0]          seed,
    input  logic [SCALE_W-1:0]         scale,
    output logic signed [SAMPLE_W-1:0] sample
);
    localparam int SAT_PROD = ((SMAX + 1) << SHIFT) / (2 ** SCALE_W - 1) + 1;

    logic [IDX_W-1:0] idx [2];

    for (genvar g = 0; g < 2; g++) begin : g_gen
        gng_lfsr #(.LANE(LANE), .GEN(g)) i_lfsr (
            .clk     (clk),
            .rst_n   (rst_n),
            .advance (en),
            .load    (seed_load),
            .seed    (seed),
            .idx     (idx[g])
        );
    end

    lane_pipe_t p_d, p_q;
    logic signed [WIDE_W-1:0] wide;
    logic signed [WIDE_W-1:0] shifted;

    always_comb begin
        p_d      = p_q;
        p_d.rad  = RAD_TAB[idx[0]];
        p_d.ang  = ANG_TAB[idx[1]];
        p_d.prod = $signed({1'b0, p_q.rad}) * p_q.ang;
        wide     = p_q.prod * $signed({1'b0, scale});
        shifted  = wide >>> SHIFT;
        if (shifted > $signed(WIDE_W'(SMAX)))      p_d.smp = SAMPLE_W'(SMAX);
        else if (shifted < $signed(WIDE_W'(SMIN))) p_d.smp = SAMPLE_W'(SMIN);
        else                                       p_d.smp = shifted[SAMPLE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign sample = p_q.smp;

    p_zero_scale_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scale == '0) |=> p_q.smp == '0);

    p_sat_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scale == '1 && p_q.prod >= SAT_PROD) |=> p_q.smp == SAMPLE_W'(SMAX));

    p_sat_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (scale == '1 && p_q.prod <= -SAT_PROD) |=> p_q.smp == SAMPLE_W'(SMIN));
endmodule

// File: rtl/gng_array.sv
module gng_array
    import gng_pkg::*;
#(
    parameter int LANES = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      en,
    input  logic                      seed_load,
    input  logic [LFSR_W-1:0]         seed,
    input  logic [SCALE_W-1:0]        scale,
    output logic [LANES*SAMPLE_W-1:0] samples,
    output logic                      valid
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic signed [SAMPLE_W-1:0] smp;
        gng_lane #(.LANE(i)) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en),
            .seed_load (seed_load),
            .seed      (seed),
            .scale     (scale),
            .sample    (smp)
        );
        assign samples[i*SAMPLE_W +: SAMPLE_W] = smp;
    end

    top_t t_d, t_q;

    always_comb begin
        t_d       = t_q;
        t_d.vpipe = {t_q.vpipe[1:0], en};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign valid = t_q.vpipe[2];

    p_valid_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> ##3 valid);

    p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> ##3 !valid);
endmodule

// File: tb/test_gng_array.sv
`timescale 1ns/1ps
module test_gng_array;
    localparam int L = 16;
    localparam logic [63:0] K = 64'h9E3779B97F4A7C15;

    logic clk = 0, rst_n = 0, en = 0, seed_load = 0;
    logic [63:0] seed = '0;
    logic [7:0] scale = 8'd16;
    logic [L*6-1:0] samples;
    logic valid;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    gng_array #(.LANES(L)) i_gng_array (
        .clk(clk), .rst_n(rst_n), .en(en), .seed_load(seed_load),
        .seed(seed), .scale(scale), .samples(samples), .valid(valid)
    );

    always #10 clk = ~clk;

    // reference model built from the requirements
    logic [63:0] mA [L], mB [L];
    int m_rad [L], m_ang [L], m_prod [L], m_smp [L];
    logic [2:0] m_v;

    function automatic int rnd(input real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    function automatic int rad_ref(input int k);
        int v;
        v = rnd($sqrt(-2.0 * $ln(($itor(k) + 0.5) / 256.0)) * 64.0);
        return (v > 255) ? 255 : v;
    endfunction

    function automatic int ang_ref(input int k);
        return rnd($cos(6.283185307179586 * ($itor(k) + 0.5) / 256.0) * 127.0);
    endfunction

    function automatic logic [63:0] mix(input logic [63:0] s, input int lane, input int g);
        logic [63:0] v;
        v = s ^ 64'(K * 64'(2 * lane + g + 1));
        return (v == 0) ? '1 : v;
    endfunction

    function automatic logic [63:0] step8(input logic [63:0] s);
        logic [63:0] x = s;
        for (int i = 0; i < 8; i++) x = {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
        return x;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < L; l++) begin
                mA[l] = mix(64'd0, l, 0); mB[l] = mix(64'd0, l, 1);
                m_rad[l] = 0; m_ang[l] = 0; m_prod[l] = 0; m_smp[l] = 0;
            end
            m_v = 0;
        end else begin
            for (int l = 0; l < L; l++) begin
                longint w;
                w = longint'(m_prod[l]) * longint'(scale);
                w = w >>> 17;
                m_smp[l] = (w > 31) ? 31 : (w < -32) ? -32 : int'(w);
                m_prod[l] = m_rad[l] * m_ang[l];
                m_rad[l] = rad_ref(int'(mA[l][63:56]));
                m_ang[l] = ang_ref(int'(mB[l][63:56]));
                if (seed_load) begin
                    mA[l] = mix(seed, l, 0); mB[l] = mix(seed, l, 1);
                end else if (en) begin
                    mA[l] = step8(mA[l]); mB[l] = step8(mB[l]);
                end
            end
            m_v = {m_v[1:0], en};
        end
    end

    function automatic logic [L*6-1:0] exp_bus();
        logic [L*6-1:0] b;
        for (int l = 0; l < L; l++) b[l*6 +: 6] = 6'(m_smp[l]);
        return b;
    endfunction

    task automatic check_out(input string tag);
        n_checks++;
        if (valid !== m_v[2]) begin
            n_fail++;
            $display("FAIL %s valid: actual %b expected %b", tag, valid, m_v[2]);
        end else if (m_v[2] && samples !== exp_bus()) begin
            n_fail++;
            $display("FAIL %s samples: actual %h expected %h", tag, samples, exp_bus());
        end
    endtask

    task automatic cyc(input bit e, input bit ld, input string tag);
        en = e; seed_load = ld;
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (valid !== 1'b0 || samples !== '0) begin
            n_fail++;
            $display("FAIL R1 in reset: actual %b/%h expected 0/0", valid, samples);
        end
        rst_n = 1;
        @(negedge clk);
        n_checks++;
        if (valid !== 1'b0 || samples !== '0) begin
            n_fail++;
            $display("FAIL R1 after reset: actual %b/%h expected 0/0", valid, samples);
        end
    endtask

    task automatic t_stream();
        int differ = 0;
        scale = 8'd16;
        for (int i = 0; i < 4; i++) cyc(0, 0, "R2 reset-seed idle");
        for (int i = 0; i < 20; i++) cyc(1, 0, "R4 R5 reset-seed stream");
        seed = 64'h0123456789ABCDEF;
        cyc(0, 1, "R3 load");
        for (int i = 0; i < 40; i++) begin
            scale = 8'(16 + 3 * i);
            cyc(1, 0, "R5 stream");
            if (valid && samples[5:0] !== samples[11:6]) differ++;
        end
        n_checks++;
        if (differ == 0) begin
            n_fail++;
            $display("FAIL R8 lanes identical: actual %0d expected >0", differ);
        end
    endtask

    task automatic t_gaps();
        bit pat [12] = '{1, 0, 0, 1, 1, 0, 1, 0, 0, 0, 1, 1};
        scale = 8'd40;
        for (int r = 0; r < 3; r++)
            foreach (pat[i]) cyc(pat[i], 0, "R7 R2 gaps");
        for (int i = 0; i < 4; i++) cyc(0, 0, "R7 drain");
    endtask

    task automatic t_saturate();
        int hits = 0;
        scale = 8'hFF;
        for (int i = 0; i < 60; i++) begin
            cyc(1, 0, "R6 saturation");
            if (m_v[2])
                for (int l = 0; l < L; l++) if (m_smp[l] == 31 || m_smp[l] == -32) hits++;
        end
        n_checks++;
        if (hits == 0) begin
            n_fail++;
            $display("FAIL R6 no saturated sample: actual %0d expected >0", hits);
        end
    endtask

    task automatic t_zero_scale();
        scale = 8'd0;
        for (int i = 0; i < 12; i++) begin
            cyc(1, 0, "R9 zero scale");
            if (valid) begin
                n_checks++;
                if (samples !== '0) begin
                    n_fail++;
                    $display("FAIL R9 samples: actual %h expected 0", samples);
                end
            end
        end
    endtask

    task automatic t_seed_edge();
        scale = 8'd24;
        seed = K;  // lane 0 radius generator would get zero: replaced by all ones
        cyc(1, 1, "R3 zero-seed load with en");
        for (int i = 0; i < 16; i++) cyc(1, 0, "R3 after zero-seed");
        seed = 64'hFEDCBA9876543210;
        for (int i = 0; i < 5; i++) cyc(1, 0, "R3 before reload");
        cyc(1, 1, "R3 reload mid-stream");
        for (int i = 0; i < 10; i++) cyc(1, 0, "R3 after reload");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_stream();
        t_gaps();
        t_saturate();
        t_zero_scale();
        t_seed_edge();
        t_reset();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule